// File: doc/BRIEF.md
# Two-Bit Burst Address Sequencer

This block produces the address a synchronous burst memory uses during a four-beat access. A burst begins when either of two active-low address strobes is sampled low. At that point the full external address is captured. The upper bits are held unchanged for the rest of the burst. The two low bits become the starting offset of a 2-bit beat sequence.

On each later rising edge where the active-low advance input is low, the sequence moves on by one beat. It never carries into the upper address bits. It wraps within the aligned group of four.

An order-select input is sampled together with the strobe. When it is low, the beats count upward modulo four from the start offset. When it is high, each offset is the start XOR the beat number. The advance input does not depend on whether the memory's data output is enabled. A read whose output is turned off still steps the offset like any other read. A new address may be loaded on every cycle, and the counter need not be used at all.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rst_n` is low at a rising edge, the design resets. After that edge, `beat_ofs` is 0, `addr_out` is all zeros, and the order is interleaved.
- R2: A load happens at any rising edge where `proc_strobe_n` or `ctrl_strobe_n` is low, or both. After that edge, `addr_out` equals the sampled `addr_in` and `beat_ofs` equals `addr_in[1:0]`.
- R3: After a load, the offset changes only at rising edges where `adv_n` is low. When `adv_n` is high and no strobe is low, `beat_ofs` and `addr_out` hold their values.
- R4: If `linear_n` is low at the load edge, beat n (n = 0..3, where n counts advances since the load) gives `beat_ofs` = (start + n) mod 4.
- R5: If `linear_n` is high at the load edge, beat n gives `beat_ofs` = start XOR n.
- R6: An advance past the fourth beat returns `beat_ofs` to the start offset. `addr_out[ADDR_W-1:2]` never changes because of an advance.
- R7: When a strobe and `adv_n` are both low at the same edge, the load wins. `beat_ofs` becomes the new start offset and does not move past it.
- R8: Loads on consecutive edges each take effect in the very next cycle, with no idle cycle between them.
- R9: Between loads, `addr_out[ADDR_W-1:2]` keeps the value captured at the last load, whatever `addr_in` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| proc_strobe_n | input | 1 | Processor-side address strobe, active low, loads the address |
| ctrl_strobe_n | input | 1 | Controller-side address strobe, active low, loads the address |
| adv_n | input | 1 | Advance to the next beat, active low |
| linear_n | input | 1 | Order select sampled at load: low = linear, high = interleaved |
| addr_in | input | ADDR_W | External address; low two bits give the start offset |
| addr_out | output | ADDR_W | Held upper address bits concatenated with the current offset |
| beat_ofs | output | 2 | Current 2-bit burst offset |

## Verification
The hardest case to reach is an advance that crosses the end of the four-beat group. A load must come first, then four or more uninterrupted advances, and this must be done for every start offset in both orders. The stimulus covers it with a nested sweep: for every start value and for both order settings, it loads once and then advances six times. Interleaved loads and collisions with the advance input are mixed into this sweep. A randomized phase follows, in which both strobes, the advance input and the order input toggle freely.

// File: rtl/burst_seq_pkg.sv
// Package: shared widths and types for the burst address sequencer.
// Assumes a fixed four-beat burst group, so the offset is two bits wide.
package burst_seq_pkg;
    localparam int OFS_W = 2;
    localparam int BEATS = 1 << OFS_W;

    typedef logic [OFS_W-1:0] ofs_t;

    typedef enum logic {
        ORD_INTLV  = 1'b0,
        ORD_LINEAR = 1'b1
    } order_e;
endpackage

// File: rtl/burst_load_ctrl.sv
// Module: burst_load_ctrl
// Decodes the two active-low strobes and the active-low advance input
// into one-hot-or-idle load/step commands. A load always wins over a step.
// Assumes all inputs are already synchronous to the sequencer clock.
module burst_load_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic proc_strobe_n,
    input  logic ctrl_strobe_n,
    input  logic adv_n,
    output logic load,
    output logic step
);
    // Command decode: either strobe loads; advance only without a load.
    always_comb begin
        load = !proc_strobe_n || !ctrl_strobe_n;
        step = !adv_n && !load;
    end

    // R7: a strobe edge must never be treated as an advance.
    p_strobe_blocks_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!proc_strobe_n || !ctrl_strobe_n) |-> !step);
endmodule

// File: rtl/burst_beat_cnt.sv
// Module: burst_beat_cnt
// Holds the start offset, the order captured at load, and the count of
// beats taken since the load. The count wraps modulo four.
// Assumes load and step are never high together (guaranteed upstream).
module burst_beat_cnt
    import burst_seq_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   load,
    input  logic   step,
    input  ofs_t   start_in,
    input  order_e order_in,
    output ofs_t   start_q,
    output ofs_t   beat_q,
    output order_e order_q
);
    // State update: reset, capture on load, or wrap-increment on step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= '0;
            beat_q  <= '0;
            order_q <= ORD_INTLV;
        end else if (load) begin
            start_q <= start_in;
            beat_q  <= '0;
            order_q <= order_in;
        end else if (step) begin
            beat_q  <= beat_q + ofs_t'(1);
        end
    end

    // R3: with no command the beat count and start stay put.
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !step) |=> ($stable(beat_q) && $stable(start_q)));

    // R6: the fourth beat wraps back to beat zero.
    p_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (step && beat_q == ofs_t'(BEATS - 1)) |=> (beat_q == '0));

    // R7: a load restarts the count even if advance was also requested.
    p_load_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (beat_q == '0));
endmodule

// File: rtl/burst_ofs_map.sv
// Module: burst_ofs_map
// Maps start offset and beat number to the burst offset, either as
// modular addition (linear) or bitwise XOR (interleaved).
// Purely combinational; assumes inputs come from registers.
module burst_ofs_map
    import burst_seq_pkg::*;
(
    input  ofs_t   start,
    input  ofs_t   beat,
    input  order_e order,
    output ofs_t   ofs
);
    ofs_t lin_ofs;
    ofs_t ilv_ofs;

    // Per-bit XOR for the interleaved order.
    for (genvar i = 0; i < OFS_W; i++) begin : g_xor
        assign ilv_ofs[i] = start[i] ^ beat[i];
    end

    // Linear order adds and drops the carry; the order selects the result.
    always_comb begin
        lin_ofs = start + beat;
        ofs     = (order == ORD_LINEAR) ? lin_ofs : ilv_ofs;
    end
endmodule

// File: rtl/burst_addr_seq.sv
// Module: burst_addr_seq (top)
// Captures an external address on either strobe. It holds the upper bits
// and sequences the two low bits through a four-beat burst in linear or
// interleaved order. Assumes ADDR_W > 2 and synchronous inputs.
module burst_addr_seq
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              proc_strobe_n,
    input  logic              ctrl_strobe_n,
    input  logic              adv_n,
    input  logic              linear_n,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_out,
    output logic [OFS_W-1:0]  beat_ofs
);
    localparam int UP_W = ADDR_W - OFS_W;

    logic              load;
    logic              step;
    ofs_t              start_q;
    ofs_t              beat_q;
    order_e            order_q;
    order_e            order_in;
    logic [UP_W-1:0]   upper_q;

    burst_load_ctrl u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .proc_strobe_n (proc_strobe_n),
        .ctrl_strobe_n (ctrl_strobe_n),
        .adv_n         (adv_n),
        .load          (load),
        .step          (step)
    );

    // Order select decode: low pin means linear.
    assign order_in = linear_n ? ORD_INTLV : ORD_LINEAR;

    burst_beat_cnt u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .step     (step),
        .start_in (addr_in[OFS_W-1:0]),
        .order_in (order_in),
        .start_q  (start_q),
        .beat_q   (beat_q),
        .order_q  (order_q)
    );

    burst_ofs_map u_map (
        .start (start_q),
        .beat  (beat_q),
        .order (order_q),
        .ofs   (beat_ofs)
    );

    // Upper address register: loaded only by a strobe, never by an advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upper_q <= '0;
        end else if (load) begin
            upper_q <= addr_in[ADDR_W-1:OFS_W];
        end
    end

    // Output assembly: held upper bits with the live offset.
    assign addr_out = {upper_q, beat_ofs};

    // R2: the offset after a load equals the sampled low address bits.
    p_load_ofs_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (beat_ofs == $past(addr_in[OFS_W-1:0])));

    // R9: upper bits only change on a load.
    p_upper_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(addr_out[ADDR_W-1:OFS_W]));

    // R4: a linear advance moves the offset up by one, modulo four.
    p_linear_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (step && order_q == ORD_LINEAR) |=>
            (beat_ofs == ofs_t'($past(beat_ofs) + ofs_t'(1))));

    // R5: an interleaved advance yields start XOR next beat number.
    p_intlv_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (step && order_q == ORD_INTLV) |=>
            (beat_ofs == (start_q ^ ofs_t'($past(beat_q) + ofs_t'(1)))));
endmodule

// File: tb/burst_addr_seq_tb.sv
`timescale 1ns/1ps
module burst_addr_seq_tb;
    localparam int AW = 18;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          proc_strobe_n = 1'b1;
    logic          ctrl_strobe_n = 1'b1;
    logic          adv_n = 1'b1;
    logic          linear_n = 1'b1;
    logic [AW-1:0] addr_in = '0;
    logic [AW-1:0] addr_out;
    logic [1:0]    beat_ofs;

    int checks = 0;
    int errors = 0;
    int cyc_cnt = 0;
    string cur_tag = "R1";
    string m_tag = "R1";
    bit done = 0;

    // Reference model state
    int m_start = 0;
    int m_n = 0;
    int m_lin = 0;
    int m_upper = 0;

    burst_addr_seq #(.ADDR_W(AW)) u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .proc_strobe_n (proc_strobe_n),
        .ctrl_strobe_n (ctrl_strobe_n),
        .adv_n         (adv_n),
        .linear_n      (linear_n),
        .addr_in       (addr_in),
        .addr_out      (addr_out),
        .beat_ofs      (beat_ofs)
    );

    always #4 clk = ~clk;

    // Behavioural reference: updated with the inputs seen at each rising edge.
    always @(posedge clk) begin
        m_tag = cur_tag;
        if (!rst_n) begin
            m_start = 0; m_n = 0; m_lin = 0; m_upper = 0;
        end else if (!proc_strobe_n || !ctrl_strobe_n) begin
            m_start = int'(addr_in[1:0]);
            m_n = 0;
            m_lin = linear_n ? 0 : 1;
            m_upper = int'(addr_in[AW-1:2]);
        end else if (!adv_n) begin
            m_n = (m_n + 1) % 4;
        end
    end

    // Compare on every falling edge.
    always @(negedge clk) begin
        int exp_ofs;
        int exp_addr;
        if (!done) begin
            exp_ofs = m_lin ? (m_start + m_n) % 4 : (m_start ^ m_n);
            exp_addr = m_upper * 4 + exp_ofs;
            checks++;
            if (int'(beat_ofs) != exp_ofs || int'(addr_out) != exp_addr) begin
                errors++;
                $display("FAIL %s: ofs=%0d addr=%0h expected ofs=%0d addr=%0h",
                         m_tag, beat_ofs, addr_out, exp_ofs, exp_addr);
            end
        end
    end

    task automatic drive(input bit ps, input bit cs, input bit adv,
                         input bit lin, input logic [AW-1:0] a, input string tag);
        @(posedge clk);
        #1;
        proc_strobe_n = ps; ctrl_strobe_n = cs; adv_n = adv;
        linear_n = lin; addr_in = a; cur_tag = tag;
    endtask

    // Watchdog: a hung run counts as a failure and still summarises.
    initial begin
        while (cyc_cnt < 100000) begin
            @(posedge clk);
            cyc_cnt++;
        end
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog: cycles=%0d expected below 100000", cyc_cnt);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        drive(1, 1, 1, 1, 18'h3ffff, "R1");
        drive(1, 1, 0, 1, 18'h3ffff, "R1");
        drive(1, 1, 1, 1, '0, "R1");
        drive(1, 1, 1, 1, '0, "R1");
        rst_n = 1'b1;
        // R2 load through each strobe
        drive(0, 1, 1, 0, 18'h12345, "R2");
        drive(1, 1, 1, 0, 18'h00000, "R9");
        drive(1, 0, 1, 1, 18'h2abc6, "R2");
        drive(1, 1, 1, 0, 18'h3ffff, "R3");
        drive(0, 0, 1, 0, 18'h0a5a7, "R2");
        // R4/R5/R6 sweep of every start in both orders, with wrap
        for (int lin = 0; lin < 2; lin++) begin
            for (int s = 0; s < 4; s++) begin
                drive(s[0], !s[0], 1, lin[0], 18'h15550 | 18'(s), "R2");
                for (int k = 0; k < 6; k++)
                    drive(1, 1, 0, 1, 18'h3fff0, lin ? "R5" : "R4");
                drive(1, 1, 0, 0, 18'h3fff0, "R6");
                // R3 hold with advance deasserted
                drive(1, 1, 1, 0, 18'h00001, "R3");
                drive(1, 1, 1, 1, 18'h00002, "R3");
            end
        end
        // R7 strobe and advance together
        drive(0, 1, 1, 0, 18'h00401, "R2");
        drive(1, 1, 0, 0, 18'h00401, "R4");
        drive(0, 1, 0, 0, 18'h00802, "R7");
        drive(1, 0, 0, 1, 18'h00c03, "R7");
        drive(1, 1, 0, 1, 18'h00c03, "R5");
        // R8 loads on consecutive cycles
        for (int i = 0; i < 8; i++)
            drive(i[0], !i[0], i[1], i[2], 18'(i * 18'h1111 + i), "R8");
        // R9 address wiggle without loads
        for (int i = 0; i < 6; i++)
            drive(1, 1, i[0], 1, 18'($urandom), "R9");
        // Random mix
        for (int i = 0; i < 2000; i++)
            drive(($urandom % 4) != 0, ($urandom % 4) != 0, $urandom % 2,
                  $urandom % 2, 18'($urandom), "R3");
        drive(1, 1, 1, 1, '0, "R3");
        @(posedge clk);
        @(posedge clk);
        #1;
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule